// File: doc/BRIEF.md
# Software-Sequenced Bus Cycle Controller

This block is the register front end through which software launches one serial bus transaction at a time. Software programs a transfer byte count, a command code and a completion interrupt enable into a control register, and sets a start bit in the same write or a later one. The start bit raises a request to an internal arbiter. When the arbiter grants, the start bit clears and the transaction's parameters go to the serial engine. When the engine reports completion, a done flag is set. The done flag can raise an interrupt.

From the moment the start bit is set until software clears the done flag, the control register is locked and writes to it are dropped. The done flag is in a separate status register and is cleared by writing 1 to it. The command code is decoded into a read or write bus direction. The serial shifting engine and the data buffer are outside this block.

Top module: `swseq_ctrl`

## Requirements
- R1: After reset, both registers read zero, and arb_req, bus_active and irq are low.
- R2: A control write (address 0) while unlocked stores the byte count from bits 31:16, the command from bits 15:8 and the interrupt enable from bit 1. Bits 7:2 read as zero whatever was written. The count is one-based: a value of 1 is one byte.
- R3: Writing 1 to control bit 0 sets the start bit (read back at bit 0) and raises arb_req. Writing 0 to bit 0 neither sets the start bit nor raises arb_req.
- R4: A one-cycle arb_gnt pulse while the start bit is set clears the start bit and arb_req and raises bus_active after that edge. A grant while the start bit is clear has no effect, including a grant in the same cycle as the write that sets the start bit.
- R5: Command 8'h01 (register read) and 8'h02 (touch data read) give bus_write=0. Command 8'h03 (register write) and 8'h04 (bulk write) give bus_write=1. For each of these four, bus_cmd_ok=1. Any other code gives bus_cmd_ok=0 and bus_write=0.
- R6: While bus_active is high, bus_count, bus_cmd and bus_write hold the programmed values and stay stable until completion.
- R7: An eng_done pulse while bus_active is high drops bus_active and sets the done flag (status bit 0). An eng_done pulse while bus_active is low is ignored.
- R8: While locked, control writes change no field. The lock runs from the start bit being set until done is cleared, and is readable at status bit 1.
- R9: Writing 1 to status bit 0 clears done and ends the lock. Writing 0 there has no effect. If a completion pulse and the clearing write fall in the same cycle, done ends up set.
- R10: irq is registered. It is high in the cycle after done and the interrupt enable are both 1, and it falls one cycle after either of them drops.
- R11: One control write while unlocked sets the count, command, interrupt enable and start bit together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0 control, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| arb_req | output | 1 | Arbiter request, high while the start bit is set |
| arb_gnt | input | 1 | One-cycle arbiter grant pulse |
| eng_done | input | 1 | One-cycle completion pulse from the serial engine |
| bus_active | output | 1 | Granted transaction in progress |
| bus_count | output | 16 | One-based byte count for the engine |
| bus_cmd | output | 8 | Command code for the engine |
| bus_write | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_cmd_ok | output | 1 | Command maps to a serial cycle |
| irq | output | 1 | Completion interrupt request |

## Verification
Two pairs of events can land on the same clock edge. The first pair is completion and the status clear: the bench drives eng_done and a write-1 to status bit 0 in one cycle and expects done to read 1 afterwards. The second pair is the start write and a grant: the bench drives the start write and an arb_gnt pulse together and expects the start bit to remain set with bus_active low, since the grant found nothing pending. A later grant must then still be accepted.

// File: rtl/swseq_ctrl.sv
module swseq_ctrl #(
  parameter int          ADDR_W       = 2,
  parameter logic [7:0]  CMD_RD_REG   = 8'h01,
  parameter logic [7:0]  CMD_RD_TOUCH = 8'h02,
  parameter logic [7:0]  CMD_WR_REG   = 8'h03,
  parameter logic [7:0]  CMD_WR_BULK  = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              arb_req,
  input  logic              arb_gnt,
  input  logic              eng_done,
  output logic              bus_active,
  output logic [15:0]       bus_count,
  output logic [7:0]        bus_cmd,
  output logic              bus_write,
  output logic              bus_cmd_ok,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

  logic [15:0] cnt_q;
  logic [7:0]  cmd_q;
  logic        ie_q, go_q, busy_q, done_q, irq_q;

  wire locked     = go_q | busy_q | done_q;
  wire ctrl_we    = reg_wr && (reg_addr == A_CTRL) && !locked;
  wire stat_clr   = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];
  wire grant_take = go_q && arb_gnt;
  wire finish     = busy_q && eng_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cmd_q  <= '0;
      ie_q   <= 1'b0;
      go_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_we) begin
        cnt_q <= reg_wdata[31:16];
        cmd_q <= reg_wdata[15:8];
        ie_q  <= reg_wdata[1];
        if (reg_wdata[0]) go_q <= 1'b1;
      end
      if (grant_take) begin
        go_q   <= 1'b0;
        busy_q <= 1'b1;
      end
      if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (stat_clr) begin
        done_q <= 1'b0;
      end
      irq_q <= done_q & ie_q;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {cnt_q, cmd_q, 6'b0, ie_q, go_q};
      A_STAT:  reg_rdata = {30'b0, locked, done_q};
      default: reg_rdata = '0;
    endcase
  end

  always_comb begin
    bus_cmd_ok = 1'b1;
    bus_write  = 1'b0;
    case (cmd_q)
      CMD_RD_REG, CMD_RD_TOUCH: bus_write = 1'b0;
      CMD_WR_REG, CMD_WR_BULK:  bus_write = 1'b1;
      default:                  bus_cmd_ok = 1'b0;
    endcase
  end

  assign arb_req    = go_q;
  assign bus_active = busy_q;
  assign bus_count  = cnt_q;
  assign bus_cmd    = cmd_q;
  assign irq        = irq_q;

  assert_grant_clears_go_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req && arb_gnt) |=> (!arb_req && bus_active));

  assert_locked_write_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && reg_wr && reg_addr == A_CTRL) |=>
      ($stable(cnt_q) && $stable(cmd_q) && $stable(ie_q)));

  assert_done_on_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && eng_done) |=> (done_q && !bus_active));

  assert_bus_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !eng_done) |=>
      ($stable(bus_count) && $stable(bus_cmd) && $stable(bus_write)));

  assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && ie_q) |=> irq);

  assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && ie_q) |=> !irq);

  always_comb begin
    if (rst_n) assert_reserved_zero_R2: assert (reg_addr != A_CTRL || reg_rdata[7:2] == 6'b0);
  end

endmodule

// File: tb/swseq_ctrl_tb.sv
`timescale 1ns/1ps
module swseq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        arb_req, arb_gnt = 1'b0, eng_done = 1'b0;
  logic        bus_active, bus_write, bus_cmd_ok, irq;
  logic [15:0] bus_count;
  logic [7:0]  bus_cmd;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  swseq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arb_req(arb_req),
    .arb_gnt(arb_gnt), .eng_done(eng_done), .bus_active(bus_active),
    .bus_count(bus_count), .bus_cmd(bus_cmd), .bus_write(bus_write),
    .bus_cmd_ok(bus_cmd_ok), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic pulse_gnt();
    arb_gnt = 1'b1; @(negedge clk); arb_gnt = 1'b0;
  endtask

  task automatic pulse_done();
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 stat", v, 0);
    chk({arb_req, bus_active, irq} == 0, "R1 outs", {arb_req, bus_active, irq}, 0);
  endtask

  task automatic t_program_idle();
    logic [31:0] v;
    wr(2'd0, 32'h0001_02FE);
    rd(2'd0, v); chk(v == 32'h0001_0202, "R2 fields/reserved", v, 32'h0001_0202);
    chk(arb_req == 0, "R3 go=0 no req", arb_req, 0);
    rd(2'd1, v); chk(v == 0, "R3 not locked", v, 0);
  endtask

  task automatic t_full_cycle();
    logic [31:0] v;
    wr(2'd0, 32'h0005_0303);
    rd(2'd0, v); chk(v == 32'h0005_0303, "R11 one write", v, 32'h0005_0303);
    chk(arb_req == 1, "R3 req", arb_req, 1);
    chk(bus_active == 0, "R4 not yet active", bus_active, 0);
    idle(2);
    chk(arb_req == 1, "R3 req holds", arb_req, 1);
    pulse_gnt();
    rd(2'd0, v); chk(v == 32'h0005_0302, "R4 go cleared", v, 32'h0005_0302);
    chk(arb_req == 0 && bus_active == 1, "R4 active", {arb_req, bus_active}, 1);
    chk(bus_count == 5 && bus_cmd == 8'h03 && bus_write && bus_cmd_ok, "R6 bus outs",
        {bus_count, bus_cmd, 6'b0, bus_write, bus_cmd_ok}, 32'h0005_0303);
    wr(2'd0, 32'h0009_0101);
    rd(2'd0, v); chk(v == 32'h0005_0302, "R8 locked write", v, 32'h0005_0302);
    idle(3);
    chk(bus_count == 5 && bus_write == 1, "R6 stable", bus_count, 5);
    pulse_done();
    rd(2'd1, v); chk(v == 32'h3, "R7 done+lock", v, 3);
    chk(bus_active == 0, "R7 inactive", bus_active, 0);
    chk(irq == 0, "R10 irq lags", irq, 0);
    idle(1);
    chk(irq == 1, "R10 irq high", irq, 1);
    wr(2'd0, 32'h0009_0101);
    rd(2'd0, v); chk(v == 32'h0005_0302, "R8 locked while done", v, 32'h0005_0302);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk(v == 32'h3, "R9 write 0 no effect", v, 3);
    wr(2'd1, 32'h1);
    rd(2'd1, v); chk(v == 0, "R9 cleared", v, 0);
    chk(irq == 1, "R10 irq one more cycle", irq, 1);
    idle(1);
    chk(irq == 0, "R10 irq falls", irq, 0);
    wr(2'd0, 32'h0009_0100);
    rd(2'd0, v); chk(v == 32'h0009_0100, "R8 unlocked after clear", v, 32'h0009_0100);
  endtask

  task automatic t_decode();
    logic [7:0] codes [6] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h00, 8'h7F};
    logic [1:0] expv  [6] = '{2'b10, 2'b10, 2'b11, 2'b11, 2'b00, 2'b00};
    for (int i = 0; i < 6; i++) begin
      wr(2'd0, {16'd1, codes[i], 8'h00});
      chk({bus_cmd_ok, bus_write} == expv[i], "R5 decode",
          {24'b0, codes[i]}, {30'b0, expv[i]});
    end
  endtask

  task automatic t_stray();
    logic [31:0] v;
    pulse_gnt();
    chk(bus_active == 0, "R4 stray grant", bus_active, 0);
    pulse_done();
    rd(2'd1, v); chk(v == 0, "R7 stray done", v, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    arb_gnt = 1'b1;
    wr(2'd0, 32'h0002_0401);
    arb_gnt = 1'b0;
    chk(arb_req == 1 && bus_active == 0, "R4 same-cycle grant ignored",
        {arb_req, bus_active}, 2);
    pulse_gnt();
    chk(bus_active == 1 && bus_count == 2 && bus_write == 1, "R4 later grant", bus_active, 1);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1; eng_done = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; eng_done = 1'b0;
    rd(2'd1, v); chk(v[0] == 1, "R9 done wins collision", v, 1);
    idle(2);
    chk(irq == 0, "R10 irq off when ie=0", irq, 0);
    wr(2'd1, 32'h1);
    rd(2'd1, v); chk(v == 0, "R9 cleared after collision", v, 0);
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_program_idle();
    t_full_cycle();
    t_decode();
    t_stray();
    t_collide();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule